// File: doc/BRIEF.md
# Fractional STS-1 VT Compressor

This block sits on the ingress side of a circuit-emulation path that carries a partially equipped STS-1. It takes in a full 9-row by 87-column synchronous payload envelope one byte per valid cycle. Each byte comes with its row and column index. The payload carries either VT1.5 or VT2 tributaries. The block keeps the path overhead column and the bytes of the tributaries that are marked equipped, in the order they arrive. It drops the two fixed-stuff columns and every byte of an unequipped tributary. The surviving bytes leave one cycle later. The first byte of each packet is flagged, and a descriptor rides along with it: the payload length, the pad count needed to reach a configured minimum, and an optional extension word that carries the 28-bit equipped mask to the far end.

Removing bytes breaks the path parity that the far end checks. To keep the end-to-end check intact, the block accumulates the bitwise parity of the unequipped bytes it discards over one envelope. It folds that parity into the path parity byte of the next envelope.

A packet can hold either the whole envelope or one third of it (three rows). The mode, the tributary type, the mask and the header options are sampled at the first byte of each envelope.

Top module: `frac_sts1_compressor`

## Requirements
- R1: While reset is asserted, `out_valid`, `out_sop` and `out_hdr_e` are 0, and `out_len`, `out_pad` and `out_ext_word` are 0.
- R2: Column 0 (path overhead) is always output. Columns 29 and 58 (0-based, fixed stuff) are never output.
- R3: For any other column c, let k = c - 1 - (c>29) - (c>58). The group is g = k mod 7 and the member is m = (k div 7) mod M, with M = 4 for VT1.5 and M = 3 for VT2. The byte is output if and only if `cfg_equip[4g+m]` is 1. Output bytes keep their input order and appear on the cycle after the input.
- R4: With `cfg_vt2`=1, the bits `cfg_equip[4g+3]` are ignored: they count neither in N, nor in the extension word.
- R5: `out_hdr_e` equals the sampled `cfg_ext_en`. When it is 1, `out_ext_word` holds `cfg_ext_more` in bit 31, zeros in bits 30:28, and the effective mask bit 4g+m in bit 27-(4g+m). When it is 0, the word is 0.
- R6: In full-envelope mode (`cfg_third`=0), `out_sop` marks the byte at row 0, column 0. Its `out_len` is 27N+9 for VT1.5 and 36N+9 for VT2, where N is the number of effective equipped tributaries.
- R7: In third-envelope mode, `out_sop` marks the column-0 bytes of rows 0, 3 and 6. `out_len` is 9N+3 for VT1.5 and 12N+3 for VT2.
- R8: `out_pad` is `cfg_min_len` minus `out_len` when that difference is positive, and 0 otherwise.
- R9: The byte at row 1, column 0 is output XORed with the parity of all unequipped-tributary bytes (stuff columns excluded) dropped in the previous envelope. For the first envelope after reset, that parity is 0.
- R10: All configuration inputs are sampled at the row 0, column 0 byte. Changes during an envelope have no effect until the next one.
- R11: Input bytes are ignored in two cases: before the first row 0, column 0 byte after reset, and whenever row > 8 or column > 86.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | DATA_W | Envelope byte |
| in_row | input | 4 | Row index, 0..8 |
| in_col | input | 7 | Column index, 0..86 |
| cfg_vt2 | input | 1 | 1 = VT2 tributaries, 0 = VT1.5 |
| cfg_third | input | 1 | 1 = one packet per three rows |
| cfg_ext_en | input | 1 | Send the mask extension word |
| cfg_ext_more | input | 1 | Value of bit 31 of the extension word |
| cfg_equip | input | 28 | Equipped mask, bit 4g+m |
| cfg_min_len | input | LEN_W | Minimum packet payload length |
| out_valid | output | 1 | Output byte valid |
| out_data | output | DATA_W | Compressed payload byte |
| out_sop | output | 1 | First byte of a packet |
| out_hdr_e | output | 1 | Extension word present |
| out_ext_word | output | 32 | Extension header word |
| out_len | output | LEN_W | Packet payload length |
| out_pad | output | LEN_W | Pad bytes to append |

## Verification
A wrong column-to-tributary decode, or a stale latched mask, shows at the ports on the very next cycle. It appears as an extra or missing byte in the output stream, and the byte count of that packet then differs from `out_len`. An error in the parity accumulator stays hidden for a whole envelope. It shows only at the row 1 overhead byte of the following envelope, so the bench runs back-to-back envelopes with sparse masks. A miscount of effective tributaries shows at the next packet start, in `out_len`, `out_pad` and the extension word together.

// File: rtl/frac_sts1_compressor.sv
module frac_sts1_compressor #(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [3:0]        in_row,
  input  logic [6:0]        in_col,
  input  logic              cfg_vt2,
  input  logic              cfg_third,
  input  logic              cfg_ext_en,
  input  logic              cfg_ext_more,
  input  logic [27:0]       cfg_equip,
  input  logic [LEN_W-1:0]  cfg_min_len,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_hdr_e,
  output logic [31:0]       out_ext_word,
  output logic [LEN_W-1:0]  out_len,
  output logic [LEN_W-1:0]  out_pad
);
  localparam int ROWS    = 9;
  localparam int COLS    = 87;
  localparam int STUFF_A = 29;
  localparam int STUFF_B = 58;
  localparam int GROUPS  = 7;
  localparam int MASK_W  = 4 * GROUPS;
  localparam int ROW_B3  = 1;

  logic              locked;
  logic [MASK_W-1:0] mask_l;
  logic              vt2_l, third_l, ext_en_l, more_l;
  logic [LEN_W-1:0]  minlen_l;
  logic [DATA_W-1:0] acc_par, prev_par;

  logic pos_ok, spe_start, take;
  assign pos_ok    = (in_row < 4'(ROWS)) && (in_col < 7'(COLS));
  assign spe_start = in_valid && pos_ok && in_row == 4'd0 && in_col == 7'd0;
  assign take      = in_valid && pos_ok && (locked || spe_start);

  logic [MASK_W-1:0] s_mask;
  logic              s_vt2, s_third, s_ext_en, s_more;
  logic [LEN_W-1:0]  s_minlen;
  assign s_mask   = spe_start ? cfg_equip    : mask_l;
  assign s_vt2    = spe_start ? cfg_vt2      : vt2_l;
  assign s_third  = spe_start ? cfg_third    : third_l;
  assign s_ext_en = spe_start ? cfg_ext_en   : ext_en_l;
  assign s_more   = spe_start ? cfg_ext_more : more_l;
  assign s_minlen = spe_start ? cfg_min_len  : minlen_l;

  logic [MASK_W-1:0] eff;
  logic [27:0]       ext_mask;
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign eff[4*g +: 3] = s_mask[4*g +: 3];
    assign eff[4*g+3]    = s_mask[4*g+3] & ~s_vt2;
  end
  for (genvar i = 0; i < MASK_W; i++) begin : g_ext
    assign ext_mask[MASK_W-1-i] = eff[i];
  end

  logic [6:0] k;
  logic [2:0] grp;
  logic [3:0] mdiv;
  logic [1:0] mem;
  logic [4:0] idx;
  assign k    = in_col - 7'd1 - {6'd0, in_col > 7'(STUFF_A)} - {6'd0, in_col > 7'(STUFF_B)};
  assign grp  = 3'(k % 7'd7);
  assign mdiv = 4'(k / 7'd7);
  assign mem  = s_vt2 ? 2'(mdiv % 4'd3) : mdiv[1:0];
  assign idx  = {grp, 2'b00} + {3'b000, mem};

  logic is_poh, is_stuff, keep, drop_uneq;
  assign is_poh    = in_col == 7'd0;
  assign is_stuff  = in_col == 7'(STUFF_A) || in_col == 7'(STUFF_B);
  assign keep      = is_poh || (!is_stuff && eff[idx]);
  assign drop_uneq = !is_poh && !is_stuff && !eff[idx];

  logic             pkt_start;
  logic [LEN_W-1:0] n_trib, len_calc, pad_calc;
  assign pkt_start = take && is_poh &&
                     (in_row == 4'd0 || (s_third && (in_row == 4'd3 || in_row == 4'd6)));
  assign n_trib    = LEN_W'($countones(eff));
  always_comb begin
    case ({s_third, s_vt2})
      2'b00:   len_calc = LEN_W'(27) * n_trib + LEN_W'(9);
      2'b01:   len_calc = LEN_W'(36) * n_trib + LEN_W'(9);
      2'b10:   len_calc = LEN_W'(9)  * n_trib + LEN_W'(3);
      default: len_calc = LEN_W'(12) * n_trib + LEN_W'(3);
    endcase
  end
  assign pad_calc = (s_minlen > len_calc) ? s_minlen - len_calc : '0;

  logic [DATA_W-1:0] data_adj;
  assign data_adj = (in_row == 4'(ROW_B3) && is_poh) ? in_data ^ prev_par : in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked       <= 1'b0;
      mask_l       <= '0;
      vt2_l        <= 1'b0;
      third_l      <= 1'b0;
      ext_en_l     <= 1'b0;
      more_l       <= 1'b0;
      minlen_l     <= '0;
      acc_par      <= '0;
      prev_par     <= '0;
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_sop      <= 1'b0;
      out_hdr_e    <= 1'b0;
      out_ext_word <= '0;
      out_len      <= '0;
      out_pad      <= '0;
    end else begin
      out_valid <= take && keep;
      out_sop   <= pkt_start;
      if (take && keep) out_data <= data_adj;
      if (spe_start) begin
        locked   <= 1'b1;
        mask_l   <= cfg_equip;
        vt2_l    <= cfg_vt2;
        third_l  <= cfg_third;
        ext_en_l <= cfg_ext_en;
        more_l   <= cfg_ext_more;
        minlen_l <= cfg_min_len;
        prev_par <= acc_par;
        acc_par  <= '0;
      end else if (take && drop_uneq) begin
        acc_par <= acc_par ^ in_data;
      end
      if (pkt_start) begin
        out_hdr_e    <= s_ext_en;
        out_ext_word <= s_ext_en ? {s_more, 3'b000, ext_mask} : 32'd0;
        out_len      <= len_calc;
        out_pad      <= pad_calc;
      end
    end
  end

  logic [LEN_W-1:0] pkt_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                    pkt_cnt <= '0;
    else if (out_valid && out_sop) pkt_cnt <= LEN_W'(1);
    else if (out_valid)            pkt_cnt <= pkt_cnt + LEN_W'(1);
  end

  // R6
  sop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> out_valid);
  // R6
  pkt_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sop) |-> pkt_cnt < out_len);
  // R5
  ext_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> (out_ext_word[30:28] == 3'b000 && (out_hdr_e || out_ext_word == 32'd0)));
  // R4
  vt2_member_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sop && vt2_l) |-> (out_ext_word & 32'h0111_1111) == 32'd0);
  // R8
  pad_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> (out_pad == '0 || out_len + out_pad == minlen_l));
  // R11
  unlocked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> !out_valid || locked);
endmodule

// File: tb/frac_sts1_compressor_tb.sv
`timescale 1ns/1ps
module frac_sts1_compressor_tb_top;
  localparam int DATA_W = 8;
  localparam int LEN_W  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              in_valid = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic [3:0]        in_row = '0;
  logic [6:0]        in_col = '0;
  logic              cfg_vt2 = 1'b0, cfg_third = 1'b0, cfg_ext_en = 1'b0, cfg_ext_more = 1'b0;
  logic [27:0]       cfg_equip = '0;
  logic [LEN_W-1:0]  cfg_min_len = '0;
  logic              out_valid, out_sop, out_hdr_e;
  logic [DATA_W-1:0] out_data;
  logic [31:0]       out_ext_word;
  logic [LEN_W-1:0]  out_len, out_pad;

  frac_sts1_compressor #(.DATA_W(DATA_W), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_row(in_row), .in_col(in_col), .cfg_vt2(cfg_vt2), .cfg_third(cfg_third),
    .cfg_ext_en(cfg_ext_en), .cfg_ext_more(cfg_ext_more), .cfg_equip(cfg_equip),
    .cfg_min_len(cfg_min_len), .out_valid(out_valid), .out_data(out_data),
    .out_sop(out_sop), .out_hdr_e(out_hdr_e), .out_ext_word(out_ext_word),
    .out_len(out_len), .out_pad(out_pad));

  int n_checks = 0;
  int n_fail   = 0;
  int bad_bytes = 0;
  int unexp    = 0;
  int got_bytes = 0;
  logic [7:0] bench_prev = '0;

  int         byte_q[$];
  int         len_q[$];
  int         pad_q[$];
  logic [31:0] ext_q[$];
  bit         e_q[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit ref_keep(input int col, input bit vt2, input logic [27:0] mask);
    int k, g, m;
    if (col == 0) return 1'b1;
    if (col == 29 || col == 58) return 1'b0;
    k = col - 1 - (col > 29 ? 1 : 0) - (col > 58 ? 1 : 0);
    g = k % 7;
    m = (k / 7) % (vt2 ? 3 : 4);
    return mask[4*g+m];
  endfunction

  function automatic logic [27:0] eff_mask(input bit vt2, input logic [27:0] mask);
    logic [27:0] r = mask;
    if (vt2) for (int g = 0; g < 7; g++) r[4*g+3] = 1'b0;
    return r;
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      got_bytes++;
      if (byte_q.size() == 0) unexp++;
      else begin
        int e;
        e = byte_q.pop_front();
        if (out_data !== e[7:0] || out_sop !== e[8]) begin
          bad_bytes++;
          if (bad_bytes < 6)
            $display("  byte mismatch got=%0h/%0b exp=%0h/%0b", out_data, out_sop, e[7:0], e[8]);
        end
        if (e[8] && len_q.size() > 0) begin
          int el, ep; logic [31:0] ex; bit ee;
          el = len_q.pop_front(); ep = pad_q.pop_front();
          ex = ext_q.pop_front(); ee = e_q.pop_front();
          check(out_len == LEN_W'(el), "R6/R7 payload length", int'(out_len), el);
          check(out_pad == LEN_W'(ep), "R8 pad count", int'(out_pad), ep);
          check(out_hdr_e == ee, "R5 extension flag", int'(out_hdr_e), int'(ee));
          check(out_ext_word == ex, "R5/R4 extension word", int'(out_ext_word), int'(ex));
        end
      end
    end
  end

  task automatic run_spe(input int seed, input bit vt2, input bit third, input bit ext_en,
                         input bit more, input logic [27:0] mask, input int minlen,
                         input int chg_row, input logic [27:0] newmask);
    logic [7:0] acc = '0;
    logic [27:0] em;
    int n, len;
    em = eff_mask(vt2, mask);
    n = $countones(em);
    if (!third) len = vt2 ? 36*n+9 : 27*n+9;
    else        len = vt2 ? 12*n+3 : 9*n+3;
    cfg_vt2 = vt2; cfg_third = third; cfg_ext_en = ext_en; cfg_ext_more = more;
    cfg_equip = mask; cfg_min_len = LEN_W'(minlen);
    for (int r = 0; r < 9; r++) begin
      for (int c = 0; c < 87; c++) begin
        logic [7:0] d;
        bit sop;
        d = 8'((seed*97 + r*13 + c*29) ^ (c << 3) ^ (r << 5));
        if (r == chg_row && c == 0) cfg_equip = newmask;
        in_valid = 1'b1; in_row = 4'(r); in_col = 7'(c); in_data = d;
        if (ref_keep(c, vt2, em)) begin
          sop = (c == 0) && (r == 0 || (third && (r == 3 || r == 6)));
          byte_q.push_back({23'd0, sop, (r == 1 && c == 0) ? d ^ bench_prev : d});
          if (sop) begin
            len_q.push_back(len);
            pad_q.push_back(minlen > len ? minlen - len : 0);
            e_q.push_back(ext_en);
            ext_q.push_back(ext_en ? {more, 3'b000, {<<{em}}} : 32'd0);
          end
        end else if (c != 29 && c != 58) acc ^= d;
        @(posedge clk); #1;
      end
    end
    in_valid = 1'b0;
    bench_prev = acc;
  endtask

  task automatic finish_check(input string tag, input int bad0, input int unexp0);
    repeat (3) @(posedge clk);
    #1;
    check(bad_bytes == bad0, {tag, " byte stream"}, bad_bytes - bad0, 0);
    check(byte_q.size() == 0 && unexp == unexp0, {tag, " byte count"},
          byte_q.size() + unexp - unexp0, 0);
  endtask

  // R1 and R11
  task automatic t_reset_and_prelock();
    int u0, g0;
    @(negedge clk);
    check(out_valid == 0 && out_sop == 0 && out_hdr_e == 0, "R1 reset controls",
          int'({out_valid, out_sop, out_hdr_e}), 0);
    check(out_len == 0 && out_pad == 0 && out_ext_word == 0, "R1 reset descriptor",
          int'(out_len) + int'(out_pad) + int'(out_ext_word), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    g0 = got_bytes; u0 = unexp;
    cfg_equip = '1;
    for (int i = 0; i < 20; i++) begin
      in_valid = 1'b1; in_row = 4'(2 + i % 3); in_col = 7'(i);
      in_data = 8'(i * 7);
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(got_bytes == g0, "R11 bytes before first envelope", got_bytes - g0, 0);
  endtask

  // R2, R3, R5, R6: fully equipped VT1.5
  task automatic t_full_vt15();
    int b0 = bad_bytes, u0 = unexp;
    run_spe(1, 1'b0, 1'b0, 1'b1, 1'b0, 28'hFFF_FFFF, 0, -1, '0);
    finish_check("R2/R3/R6 full VT1.5", b0, u0);
  endtask

  // R4: VT2 with member-3 bits set on input
  task automatic t_full_vt2();
    int b0 = bad_bytes, u0 = unexp;
    run_spe(2, 1'b1, 1'b0, 1'b1, 1'b1, 28'hFFF_FFFF, 0, -1, '0);
    finish_check("R4 VT2 member bits ignored", b0, u0);
  endtask

  // R7, R8, R9: sparse VT1.5, third packets with padding, back to back for parity
  task automatic t_third_pad_parity();
    int b0 = bad_bytes, u0 = unexp;
    run_spe(3, 1'b0, 1'b1, 1'b1, 1'b0, 28'h000_0421, 64, -1, '0);
    run_spe(4, 1'b0, 1'b1, 1'b1, 1'b0, 28'h000_0421, 64, -1, '0);
    finish_check("R7/R8/R9 third packets and parity", b0, u0);
  endtask

  // R9 and R3: VT2 sparse with headers off
  task automatic t_vt2_sparse_noext();
    int b0 = bad_bytes, u0 = unexp;
    run_spe(5, 1'b1, 1'b0, 1'b0, 1'b1, 28'h030_2005, 200, -1, '0);
    run_spe(6, 1'b1, 1'b0, 1'b0, 1'b0, 28'h800_0001, 0, -1, '0);
    finish_check("R5/R9 VT2 sparse without extension", b0, u0);
  endtask

  // R10: mask changed mid envelope
  task automatic t_mid_change();
    int b0 = bad_bytes, u0 = unexp;
    run_spe(7, 1'b0, 1'b0, 1'b1, 1'b0, 28'h00F_0F0F, 0, 4, 28'hFFF_FFFF);
    finish_check("R10 mid-envelope mask change", b0, u0);
  endtask

  // R6 boundary N=0 and R11 out-of-range positions
  task automatic t_empty_and_range();
    int b0 = bad_bytes, u0 = unexp, g0;
    run_spe(8, 1'b0, 1'b0, 1'b1, 1'b0, 28'h000_0000, 12, -1, '0);
    finish_check("R6 empty mask", b0, u0);
    g0 = got_bytes;
    for (int i = 0; i < 10; i++) begin
      in_valid = 1'b1; in_row = 4'(9 + i % 5); in_col = 7'(i * 11);
      in_data = 8'hA5;
      @(posedge clk); #1;
    end
    for (int i = 0; i < 5; i++) begin
      in_valid = 1'b1; in_row = 4'(i); in_col = 7'(87 + i * 8);
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(got_bytes == g0, "R11 out-of-range positions", got_bytes - g0, 0);
    b0 = bad_bytes; u0 = unexp;
    run_spe(9, 1'b0, 1'b0, 1'b1, 1'b0, 28'h100_0000, 0, -1, '0);
    finish_check("R9/R11 parity unaffected by ignored bytes", b0, u0);
  endtask

  bit done = 1'b0;
  initial begin
    repeat (4) @(posedge clk);
    #1;
    t_reset_and_prelock();
    t_full_vt15();
    t_full_vt2();
    t_third_pad_parity();
    t_vt2_sparse_noext();
    t_mid_change();
    t_empty_and_range();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule